// File: doc/BRIEF.md
# Shared Interrupt Pin Router

This block gathers interrupt requests from two controller domains, a host/OTG side and a device side, and presents them on one or two external interrupt pins. Each side has its own sticky status, a global enable, an output polarity and a choice between level signalling and a fixed-width pulse. The device side also has a per-source enable mask, so that only enabled sources can raise its request.

A routing control can merge both requests onto the first pin for systems that have only one spare interrupt input. When the pins are merged, the first pin follows the host-side polarity and trigger settings, and the second pin rests at its inactive level. A two-bit sticky pending register records every enabled event, so software can find pulses that fired while its handler kept the interrupt masked.

Top module: `irq_pin_combiner`

## Requirements
- R1: A set pulse on a status bit (`host_set`, or a bit of `dev_set`) makes that bit 1 after the clock edge. A 1 on the matching clear input makes it 0, so the clears are write-1-to-clear. When set and clear arrive in the same cycle, set wins.
- R2: The device request is the AND of `dev_glb_en` with the OR over bits of `dev_stat & dev_ie`. With `dev_glb_en` low, or with a source disabled in `dev_ie`, device activity does not affect the pins. The status bits still latch.
- R3: In level mode (trigger bit 0) a pin becomes active one clock after its request becomes true. It stays active for as long as the request holds, including periods when the CPU is not servicing it. It becomes inactive one clock after the last enabled status bit clears.
- R4: In edge mode (trigger bit 1), an enabled event sampled at clock edge k makes the pin active for exactly PULSE_CYCLES cycles, starting right after edge k. The pulse ends even while the status stays set.
- R5: An enabled event that arrives during a pulse restarts the pulse at its full PULSE_CYCLES width.
- R6: Polarity bit 1 means the pin is active high. Polarity bit 0 means the pin is active low. The inactive level is the opposite one. After reset, with polarity 1, both pins are low.
- R7: With `route_merge` low, `pin_a` carries the host side using the host settings, and `pin_b` carries the device side using the device settings.
- R8: With `route_merge` high, the host and device requests and events are ORed onto `pin_a` using the host polarity and trigger settings. `pin_b` is held at its inactive level, `~dev_pol`.
- R9: An enabled host event sets `pend[0]` and an enabled device event sets `pend[1]`, in either trigger mode. Each bit stays set until a 1 on the matching `pend_clr` bit clears it. When set and clear arrive in the same cycle, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_set | input | 1 | Host/OTG event pulse |
| host_clr | input | 1 | Write-1-to-clear for host status |
| host_en | input | 1 | Host side global enable |
| dev_set | input | DEV_SRC | Device source event pulses |
| dev_clr | input | DEV_SRC | Write-1-to-clear for device status |
| dev_ie | input | DEV_SRC | Device per-source enable |
| dev_glb_en | input | 1 | Device side global enable |
| route_merge | input | 1 | 1 merges both sides onto pin_a |
| host_pol | input | 1 | Host polarity, 1 is active high |
| host_edge | input | 1 | Host trigger, 1 is pulse, 0 is level |
| dev_pol | input | 1 | Device polarity, 1 is active high |
| dev_edge | input | 1 | Device trigger, 1 is pulse, 0 is level |
| pend_clr | input | 2 | Write-1-to-clear for pending bits |
| dev_stat | output | DEV_SRC | Device status bits |
| host_stat | output | 1 | Host status bit |
| pend | output | 2 | Sticky pending events, bit 0 host, bit 1 device |
| pin_a | output | 1 | First interrupt pin |
| pin_b | output | 1 | Second interrupt pin |

## Verification
Inputs change on the falling edge and outputs are sampled on later falling edges. An event driven before rising edge k shows up in the status and pending bits at the next sample. A pulse starts at that same sample and holds for exactly PULSE_CYCLES samples. A level pin is one sample later, because it passes through one more register. The tests count samples against these latencies, so they catch an output that changes one cycle early, one cycle late, or lasts one cycle too long. The masked-handler cases leave the pins alone for many cycles and then read the level pin and the pending bits.

// File: rtl/irq_pin_combiner.sv
`timescale 1ns/1ps
module irq_pin_combiner #(
  parameter int DEV_SRC      = 8,
  parameter int PULSE_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_set,
  input  logic               host_clr,
  input  logic               host_en,
  input  logic [DEV_SRC-1:0] dev_set,
  input  logic [DEV_SRC-1:0] dev_clr,
  input  logic [DEV_SRC-1:0] dev_ie,
  input  logic               dev_glb_en,
  input  logic               route_merge,
  input  logic               host_pol,
  input  logic               host_edge,
  input  logic               dev_pol,
  input  logic               dev_edge,
  input  logic [1:0]         pend_clr,
  output logic [DEV_SRC-1:0] dev_stat,
  output logic               host_stat,
  output logic [1:0]         pend,
  output logic               pin_a,
  output logic               pin_b
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] PW = CW'(PULSE_CYCLES);

  logic host_req, dev_req, host_evt, dev_evt;
  logic [1:0] req, evt, edg, pol, act, lvl_q;
  logic [CW-1:0] cnt [2];
  logic alive_q;

  assign host_req = host_stat & host_en;
  assign dev_req  = dev_glb_en & |(dev_stat & dev_ie);
  assign host_evt = host_set & host_en;
  assign dev_evt  = dev_glb_en & |(dev_set & dev_ie);

  assign req = route_merge ? {1'b0, host_req | dev_req} : {dev_req, host_req};
  assign evt = route_merge ? {1'b0, host_evt | dev_evt} : {dev_evt, host_evt};
  assign edg = {dev_edge, host_edge};
  assign pol = {dev_pol, host_pol};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_stat <= 1'b0;
      dev_stat  <= '0;
      pend      <= '0;
      alive_q   <= 1'b0;
    end else begin
      host_stat <= (host_stat & ~host_clr) | host_set;
      dev_stat  <= (dev_stat & ~dev_clr) | dev_set;
      pend      <= (pend & ~pend_clr) | {dev_evt, host_evt};
      alive_q   <= 1'b1;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[k]   <= '0;
        lvl_q[k] <= 1'b0;
      end else begin
        lvl_q[k] <= req[k];
        if (evt[k])           cnt[k] <= PW;
        else if (cnt[k] != 0) cnt[k] <= cnt[k] - CW'(1);
      end
    end
    assign act[k] = edg[k] ? (cnt[k] != '0) : lvl_q[k];
  end

  assign pin_a = act[0] ? pol[0] : ~pol[0];
  assign pin_b = (act[1] && !route_merge) ? pol[1] : ~pol[1];

  logic [4:0] cfg;
  assign cfg = {route_merge, host_pol, host_edge, dev_pol, dev_edge};

  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    |(dev_stat & dev_clr & ~dev_set) |=> ((dev_stat & $past(dev_clr & ~dev_set)) == '0)); // R1

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !pend_clr[1]) |=> pend[1]); // R9

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(host_req && !host_edge && !route_merge) && $stable(cfg))
      |-> (pin_a == host_pol)); // R3

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(host_evt && host_edge && !route_merge) && $stable(cfg))
      |-> (pin_a == host_pol)); // R4

  AST_DEV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && !route_merge && !dev_edge && $past(!dev_glb_en) && $stable(cfg))
      |-> (pin_b == !dev_pol)); // R2
endmodule

// File: tb/irq_pin_combiner_tb_top.sv
`timescale 1ns/1ps
module irq_pin_combiner_tb_top;
  localparam int CLK_PERIOD = 40;
  localparam int N = 8;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_set = 0, host_clr = 0, host_en = 1;
  logic [N-1:0] dev_set = '0, dev_clr = '0, dev_ie = '0;
  logic dev_glb_en = 1, route_merge = 0;
  logic host_pol = 1, host_edge = 0, dev_pol = 1, dev_edge = 0;
  logic [1:0] pend_clr = '0;
  logic [N-1:0] dev_stat;
  logic host_stat, pin_a, pin_b;
  logic [1:0] pend;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_combiner #(.DEV_SRC(N), .PULSE_CYCLES(P)) dut_i (
    .clk, .rst_n, .host_set, .host_clr, .host_en, .dev_set, .dev_clr, .dev_ie,
    .dev_glb_en, .route_merge, .host_pol, .host_edge, .dev_pol, .dev_edge,
    .pend_clr, .dev_stat, .host_stat, .pend, .pin_a, .pin_b);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic lv(logic active, logic pol);
    return active ? pol : ~pol;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_pulse();
    host_set = 1; cyc(1); host_set = 0;
  endtask

  task automatic dev_pulse(logic [N-1:0] m);
    dev_set = m; cyc(1); dev_set = '0;
  endtask

  task automatic clean();
    host_clr = 1; dev_clr = '1; pend_clr = 2'b11; cyc(1);
    host_clr = 0; dev_clr = '0; pend_clr = 2'b00; cyc(P + 2);
  endtask

  task automatic t_reset();
    chk("R6 reset pin_a", pin_a, 0);
    chk("R6 reset pin_b", pin_b, 0);
    chk("R1 reset status", {host_stat, dev_stat}, 0);
    chk("R9 reset pend", pend, 0);
  endtask

  task automatic t_level_host(logic pol);
    route_merge = 0; host_edge = 0; host_pol = pol; dev_pol = 1; cyc(1);
    host_pulse();
    chk("R1 host set", host_stat, 1);
    chk("R3 level one cycle late", pin_a, lv(0, pol));
    cyc(1);
    chk("R3 R6 level active", pin_a, lv(1, pol));
    chk("R7 pin_b quiet", pin_b, 0);
    cyc(5);
    chk("R3 level held", pin_a, lv(1, pol));
    host_clr = 1; cyc(1); host_clr = 0;
    chk("R1 host clear", host_stat, 0);
    chk("R3 still active after clear edge", pin_a, lv(1, pol));
    cyc(1);
    chk("R3 deassert", pin_a, lv(0, pol));
    clean();
  endtask

  task automatic t_edge_dev(logic pol);
    route_merge = 0; dev_edge = 1; dev_pol = pol; dev_ie = 8'h04; cyc(1);
    dev_pulse(8'h04);
    for (int i = 0; i < P; i++) begin
      chk("R4 R6 pulse active", pin_b, lv(1, pol));
      cyc(1);
    end
    chk("R4 pulse ends", pin_b, lv(0, pol));
    chk("R4 status still set", dev_stat, 8'h04);
    chk("R9 dev pend", pend, 2'b10);
    chk("R7 pin_a quiet", pin_a, lv(0, host_pol));
    dev_edge = 0; clean();
  endtask

  task automatic t_retrigger();
    route_merge = 0; host_edge = 1; host_pol = 1; cyc(1);
    host_pulse();
    chk("R4 first pulse", pin_a, 1);
    cyc(1);
    host_pulse();
    for (int i = 0; i < P; i++) begin
      chk("R5 reloaded pulse", pin_a, 1);
      cyc(1);
    end
    chk("R5 pulse ends", pin_a, 0);
    host_edge = 0; clean();
  endtask

  task automatic t_merged();
    route_merge = 1; host_edge = 0; host_pol = 1; dev_pol = 0; dev_ie = 8'h01; cyc(1);
    dev_pulse(8'h01);
    chk("R8 merged pin_b inactive", pin_b, 1);
    cyc(1);
    chk("R8 device on pin_a", pin_a, 1);
    chk("R8 pin_b still inactive", pin_b, 1);
    clean();
    host_edge = 1; host_pol = 0; cyc(1);
    dev_pulse(8'h01);
    for (int i = 0; i < P; i++) begin
      chk("R8 merged pulse host cfg", pin_a, 0);
      cyc(1);
    end
    chk("R8 merged pulse ends", pin_a, 1);
    host_pulse();
    chk("R8 host on merged pin", pin_a, 0);
    chk("R8 pin_b inactive", pin_b, 1);
    clean();
    route_merge = 0; host_edge = 0; host_pol = 1; dev_pol = 1; cyc(2);
  endtask

  task automatic t_gate();
    route_merge = 0; dev_edge = 0; dev_pol = 1; dev_glb_en = 0; dev_ie = 8'h10; cyc(1);
    dev_pulse(8'h30);
    cyc(2);
    chk("R2 status latches", dev_stat, 8'h30);
    chk("R2 gated pin", pin_b, 0);
    chk("R2 gated pend", pend, 0);
    dev_glb_en = 1; cyc(2);
    chk("R2 enable raises pin", pin_b, 1);
    dev_clr = 8'h10; cyc(1); dev_clr = '0; cyc(1);
    chk("R2 masked source ignored", pin_b, 0);
    chk("R1 partial clear", dev_stat, 8'h20);
    clean();
  endtask

  task automatic t_masked();
    host_edge = 1; cyc(1);
    host_pulse();
    cyc(P + 5);
    chk("R4 missed pulse gone", pin_a, 0);
    chk("R9 pending kept", pend, 2'b01);
    pend_clr = 2'b01; host_set = 1; cyc(1); pend_clr = 0; host_set = 0;
    chk("R9 set beats clear", pend[0], 1);
    pend_clr = 2'b01; cyc(1); pend_clr = 0;
    chk("R9 pend clear", pend, 0);
    host_edge = 0; clean();
    host_pulse();
    cyc(20);
    chk("R3 level seen after mask", pin_a, 1);
    host_set = 1; host_clr = 1; cyc(1); host_set = 0; host_clr = 0;
    chk("R1 set beats clear", host_stat, 1);
    clean();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset();
    t_level_host(1);
    t_level_host(0);
    host_pol = 1;
    t_edge_dev(0);
    t_edge_dev(1);
    t_retrigger();
    t_merged();
    t_gate();
    t_masked();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule